// File: doc/BRIEF.md
# SPI Real-Time-Clock Register Slave

This block is the serial front end of a real-time clock. A host addresses it over a four-wire SPI link whose chip select is active-high. Every frame opens with a command byte. The command carries a register address and a transfer mode. Data bytes follow in the same frame. The block decodes the command and, for writes, issues single-cycle write strobes on a register port. For reads, it fetches bytes from the port, masks the bits that must not be seen, and shifts them out on MISO. Burst transfers step the address after each data byte. A burst starting at address 0 therefore moves the whole seven-byte time snapshot in one frame.

The time fields (seconds through year, BCD) sit at addresses 0 to 6. Two control registers sit at 14 and 15. The counting logic that owns those registers is a separate block. It hangs on the register port and returns read data combinationally for the address presented. SCLK, MOSI and chip select are taken as already synchronous to the system clock. SCLK is oversampled: the block finds its edges by comparing SCLK against a registered copy.

Top module: `rtc_spi_regslave`

## Requirements
- R1: While spi_cs is low, spi_miso is 0. The bit and byte counters return to their start, so the next frame always begins with a command byte.
- R2: In the command byte, bits 7:4 are the register address and bits 3:2 the mode: 2'b10 single write, 2'b11 single read, 2'b00 burst write, 2'b01 burst read. Bits 1:0 are ignored.
- R3: Bytes travel MSB first. With the default idle-high clock, MOSI is sampled on the rising (return-to-idle) edge and MISO changes on the falling (leave-idle) edge.
- R4: A write strobe (reg_we high for one clock, with reg_addr and reg_wdata valid) is raised only once all 8 bits of a data byte have arrived. Two strobes are never on adjacent clocks.
- R5: A single write stores only the first data byte. Further data bytes in that frame cause no strobe.
- R6: A single read returns the addressed register in the first data byte. Any further data bytes in that frame read as 0x00.
- R7: In burst mode the address rises by one after every data byte and wraps from 15 to 0.
- R8: Read data is masked by address: 0 and 1 with 0x7F, 2 with 0x3F, 3 with 0x07, 4 with 0x3F, 5 with 0x9F, all others unmasked. Seconds bit 7 therefore always reads 0. Writes are never masked.
- R9: A frame that ends before a data byte is complete produces no write strobe.
- R10: MISO stays 0 for the whole command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs | input | 1 | Chip select, active-high |
| spi_sclk | input | 1 | Serial clock, idles high by default |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | ADDR_W | Register address for the port |
| reg_we | output | 1 | One-clock write strobe |
| reg_wdata | output | DATA_W | Write data |
| reg_rdata | input | DATA_W | Read data for reg_addr, combinational |

## Verification
The assertions assume that SCLK sits at its idle level whenever chip select changes. They also assume that MOSI only moves on leave-idle edges, and that reg_rdata follows reg_addr within the same clock. Their strobe-spacing argument relies on each SCLK level lasting at least one system clock. The stimulus meets these conditions by construction. A host task drives all SPI pins on the falling system-clock edge and holds each SCLK level for four clocks. Chip select only toggles with SCLK idle. The bench's register array answers reg_addr through a continuous assignment. The deliberately aborted frames still end with SCLK back at idle.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;

   // Mode field of the command byte: bit 1 = single, bit 0 = read
   typedef enum logic [1:0] {
      XM_BURST_WR  = 2'b00,
      XM_BURST_RD  = 2'b01,
      XM_SINGLE_WR = 2'b10,
      XM_SINGLE_RD = 2'b11
   } xfer_mode_e;

   // Read-side visibility mask per register address
   function automatic logic [7:0] rd_mask(input logic [3:0] a);
      logic [7:0] m;
      unique case (a)
         4'd0, 4'd1: m = 8'h7F;
         4'd2:       m = 8'h3F;
         4'd3:       m = 8'h07;
         4'd4:       m = 8'h3F;
         4'd5:       m = 8'h9F;
         default:    m = 8'hFF;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/rtc_spi_edge.sv
module rtc_spi_edge #(
   parameter bit IDLE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   output logic lead,
   output logic trail
);
   logic sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= IDLE_HIGH;
      else        sclk_d <= sclk;
   end

   generate
      if (IDLE_HIGH) begin : g_idle_hi
         assign lead  =  sclk_d & ~sclk;
         assign trail = ~sclk_d &  sclk;
      end else begin : g_idle_lo
         assign lead  = ~sclk_d &  sclk;
         assign trail =  sclk_d & ~sclk;
      end
   endgenerate

endmodule

// File: rtl/rtc_spi_shifter.sv
module rtc_spi_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              trail,
   input  logic              mosi,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-2:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (!cs) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (trail) begin
         sh_q  <= {sh_q[DATA_W-3:0], mosi};
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign byte_done = cs & trail & (cnt_q == LAST);
   assign rx_byte   = {sh_q, mosi};

   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> (cnt_q == '0)); // R1

   AST_PARTIAL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && $past(cs)) |-> ($past(cnt_q) == LAST - 1'b1) || $past(trail) == 1'b0); // R9

endmodule

// File: rtl/rtc_spi_ctrl.sv
module rtc_spi_ctrl
   import rtc_spi_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 4,
   parameter bit MASK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              lead,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_we,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              miso_q
);
   localparam int MODE_LSB = DATA_W - ADDR_W - 2;

   logic [ADDR_W-1:0] addr_q;
   xfer_mode_e        mode_q;
   logic [1:0]        idx_q;   // 0 command, 1 first data, 2 later data
   logic              load_q;
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rd_val;
   logic              is_rd, is_single, data_ok, rd_phase;

   assign is_rd     = mode_q[0];
   assign is_single = mode_q[1];
   assign data_ok   = (idx_q == 2'd1) || (idx_q != 2'd0 && !is_single);
   assign rd_phase  = is_rd && data_ok;

   assign reg_addr  = addr_q;
   assign reg_wdata = rx_byte;
   assign reg_we    = byte_done && !is_rd && data_ok;

   generate
      if (MASK_EN) begin : g_mask
         assign rd_val = reg_rdata & rd_mask(addr_q);
         AST_SEC_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !cs)
            (load_q && addr_q == '0) |=> !tx_q[DATA_W-1]); // R8
      end else begin : g_raw
         assign rd_val = reg_rdata;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mode_q <= XM_BURST_WR;
         idx_q  <= '0;
         load_q <= 1'b0;
         tx_q   <= '0;
         miso_q <= 1'b0;
      end else if (!cs) begin
         idx_q  <= '0;
         load_q <= 1'b0;
         tx_q   <= '0;
         miso_q <= 1'b0;
      end else begin
         load_q <= 1'b0;
         if (byte_done) begin
            if (idx_q == 2'd0) begin
               addr_q <= rx_byte[DATA_W-1 -: ADDR_W];
               mode_q <= xfer_mode_e'(rx_byte[MODE_LSB +: 2]);
               idx_q  <= 2'd1;
               load_q <= rx_byte[MODE_LSB];
            end else begin
               idx_q <= 2'd2;
               if (!is_single) begin
                  addr_q <= addr_q + 1'b1;
                  load_q <= is_rd;
               end
            end
         end
         if (load_q)
            tx_q <= rd_val;
         else if (lead && rd_phase)
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
         if (lead)
            miso_q <= rd_phase ? tx_q[DATA_W-1] : 1'b0;
      end
   end

   // checker state: strobes seen in the current frame
   logic [1:0] wr_seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        wr_seen_q <= '0;
      else if (!cs)                      wr_seen_q <= '0;
      else if (reg_we && wr_seen_q != 2'd3) wr_seen_q <= wr_seen_q + 1'b1;
   end

   AST_SINGLE_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && is_single) |-> (wr_seen_q == 2'd0)); // R5

   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n || !cs)
      (byte_done && idx_q != 2'd0 && !is_single) |=> (addr_q == $past(addr_q) + 1'b1)); // R7

   AST_CMD_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && idx_q == 2'd0) |-> !miso_q); // R10

endmodule

// File: rtl/rtc_spi_regslave.sv
module rtc_spi_regslave #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter bit IDLE_HIGH = 1'b1,
   parameter bit MASK_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_we,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("DATA_W must be 8: the read masks are byte wide");
      end
      if (ADDR_W + 4 != DATA_W) begin : g_bad_addr
         $error("ADDR_W must fill the upper nibble of the command byte");
      end
   endgenerate

   logic              lead, trail, byte_done, miso_q;
   logic [DATA_W-1:0] rx_byte;

   rtc_spi_edge #(.IDLE_HIGH(IDLE_HIGH)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sclk  (spi_sclk),
      .lead  (lead),
      .trail (trail)
   );

   rtc_spi_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs        (spi_cs),
      .trail     (trail),
      .mosi      (spi_mosi),
      .byte_done (byte_done),
      .rx_byte   (rx_byte)
   );

   rtc_spi_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_EN(MASK_EN)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs        (spi_cs),
      .lead      (lead),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .reg_rdata (reg_rdata),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .miso_q    (miso_q)
   );

   assign spi_miso = spi_cs & miso_q;

   AST_WE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we); // R4

endmodule

// File: tb/rtc_spi_regslave_tb.sv
`timescale 1ns/1ps
module rtc_spi_regslave_tb;
   localparam int HALF = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_cs = 1'b0, spi_sclk = 1'b1, spi_mosi = 1'b0;
   logic       spi_miso;
   logic [3:0] reg_addr;
   logic       reg_we;
   logic [7:0] reg_wdata, reg_rdata;

   logic [7:0] periph [16];   // register array answering the port
   logic [7:0] exp_mem [16];  // bench's own expectation
   logic [11:0] exp_wr [$];
   int checks = 0, fails = 0, cycles = 0;

   always #2 clk = ~clk;

   rtc_spi_regslave u_dut (
      .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   assign reg_rdata = periph[reg_addr];

   always @(posedge clk) if (rst_n && reg_we) periph[reg_addr] <= reg_wdata;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] vis(input int a);
      case (a)
         0, 1:    return 8'h7F;
         2:       return 8'h3F;
         3:       return 8'h07;
         4:       return 8'h3F;
         5:       return 8'h9F;
         default: return 8'hFF;
      endcase
   endfunction

   // per-clock reference comparison
   always begin
      @(negedge clk);
      #1;
      if (rst_n) begin
         if (!spi_cs) chk("R1 idle miso", spi_miso, 1'b0);
         if (reg_we) begin
            if (exp_wr.size() == 0) chk("R4/R5/R9 unexpected strobe", {reg_addr, reg_wdata}, 12'hFFF);
            else chk("R4 strobe addr/data", {reg_addr, reg_wdata}, exp_wr.pop_front());
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected below 150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk); spi_sclk = 1'b0; spi_mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = spi_miso; spi_sclk = 1'b1;
         repeat (HALF - 1) @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic cs_on();
      @(negedge clk); spi_cs = 1'b1; repeat (2) @(negedge clk);
   endtask

   task automatic cs_off();
      repeat (2) @(negedge clk); spi_cs = 1'b0; repeat (3) @(negedge clk);
   endtask

   task automatic expect_wr(input int a, input logic [7:0] d);
      exp_wr.push_back({4'(a), d});
      exp_mem[a] = d;
   endtask

   task automatic send_cmd(input logic [7:0] c);
      logic [7:0] r;
      xfer(c, r);
      chk("R10 miso during command", r, 8'h00);
   endtask

   initial begin
      logic [7:0] r;
      logic [7:0] wv [7];
      for (int i = 0; i < 16; i++) begin periph[i] = 8'h00; exp_mem[i] = 8'h00; end
      repeat (3) @(negedge clk);
      chk("R1 reset miso", spi_miso, 1'b0);
      chk("R4 reset strobe", reg_we, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R7 burst write of the time snapshot from address 0
      wv = '{8'h59, 8'h58, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99};
      cs_on(); send_cmd(8'h00);
      for (int i = 0; i < 7; i++) begin expect_wr(i, wv[i]); xfer(wv[i], r); end
      cs_off();

      // R3 R8 burst read of the snapshot
      cs_on(); send_cmd(8'h04);
      for (int i = 0; i < 7; i++) begin
         xfer(8'h00, r);
         chk("R3/R8 burst read", r, exp_mem[i] & vis(i));
      end
      cs_off();

      // R5 single write to seconds with an extra byte, R8 top bit hidden
      cs_on(); send_cmd(8'h08);
      expect_wr(0, 8'hD9); xfer(8'hD9, r); xfer(8'h77, r);
      cs_off();
      chk("R5 extra byte ignored", exp_wr.size(), 0);
      cs_on(); send_cmd(8'h0C);
      xfer(8'h00, r); chk("R8 seconds bit7 reads 0", r, 8'h59);
      xfer(8'h00, r); chk("R6 single read second byte", r, 8'h00);
      cs_off();

      // control 1 written and read unmasked
      cs_on(); send_cmd(8'hE8); expect_wr(14, 8'h20); xfer(8'h20, r); cs_off();
      cs_on(); send_cmd(8'hEC); xfer(8'h00, r); chk("R6 single read ctrl1", r, 8'h20); cs_off();

      // R7 burst write wraps 14 -> 15 -> 0
      cs_on(); send_cmd(8'hE0);
      expect_wr(14, 8'h70); xfer(8'h70, r);
      expect_wr(15, 8'h50); xfer(8'h50, r);
      expect_wr(0,  8'h92); xfer(8'h92, r);
      cs_off();
      cs_on(); send_cmd(8'hF4);
      xfer(8'h00, r); chk("R7 burst read addr15", r, exp_mem[15]);
      xfer(8'h00, r); chk("R7 wrap to addr0", r, exp_mem[0] & vis(0));
      xfer(8'h00, r); chk("R7 wrap to addr1", r, exp_mem[1] & vis(1));
      cs_off();

      // clearing control 2 by writing zero
      cs_on(); send_cmd(8'hF8); expect_wr(15, 8'h00); xfer(8'h00, r); cs_off();
      cs_on(); send_cmd(8'hFC); xfer(8'h00, r); chk("R2 ctrl2 cleared", r, 8'h00); cs_off();

      // R2 low command bits ignored
      cs_on(); send_cmd(8'h5B); expect_wr(5, 8'h92); xfer(8'h92, r); cs_off();
      cs_on(); send_cmd(8'h5F); xfer(8'h00, r); chk("R2 low bits ignored", r, 8'h92 & vis(5)); cs_off();

      // R9 frame aborted after 5 data bits: no strobe
      cs_on(); send_cmd(8'h38);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); spi_sclk = 1'b0; spi_mosi = 1'b1;
         repeat (HALF) @(negedge clk); spi_sclk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      cs_off();
      chk("R9 no strobe after abort", exp_wr.size(), 0);
      // R1 abort mid-command, next frame starts cleanly
      cs_on();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); spi_sclk = 1'b0; spi_mosi = 1'b1;
         repeat (HALF) @(negedge clk); spi_sclk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      cs_off();
      cs_on(); send_cmd(8'h3C); xfer(8'h00, r);
      chk("R1 counters reset, weekday", r, exp_mem[3] & vis(3));
      cs_off();

      repeat (5) @(negedge clk);
      chk("R4 all strobes seen", exp_wr.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule